// File: doc/BRIEF.md
# Big-endian load/store alignment unit

This block sits between a 32-bit processor datapath and a data memory that is one word wide and addressed by byte. On a load, it takes the word fetched from memory and picks out the byte or halfword that the address names. It then widens that value to 32 bits, either by copying the sign bit upward or by filling with zeros, as the access control asks. On a store, it copies the narrow store data onto every lane it could occupy and raises the byte write enables only for the lanes the address selects. Lanes are numbered big-endian: the lowest address offset inside a word is the most significant byte.

An access whose address breaks the alignment rule for its size is not carried out. The block raises an error flag, drops every byte enable and returns a zero load result. The datapath itself is combinational. A parameter places an optional register stage on all outputs, and that stage is enabled by default.

Top module: `lsa_align_unit`

## Requirements
- R1: With access control 3'b000 (word) and address offset 0, the load result equals the fetched word unchanged.
- R2: A byte load takes bits 31:24, 23:16, 15:8 or 7:0 of the fetched word for address offsets 0, 1, 2 and 3.
- R3: A halfword load takes bits 31:16 for offset 0 and bits 15:0 for offset 2.
- R4: The signed controls, 3'b001 (halfword) and 3'b011 (byte), copy the top bit of the selected value into every upper bit of the result.
- R5: The unsigned controls, 3'b010 (halfword) and 3'b100 (byte), fill every upper bit of the result with zero.
- R6: A word store at offset 0 drives byte enable 4'b1111 and writes the store data unchanged. Enable bit 3 is the lane for bits 31:24, and bit 0 is the lane for bits 7:0.
- R7: A halfword store drives enable 4'b1100 at offset 0 and 4'b0011 at offset 2, and writes store bits 15:0 into both halves of the write word.
- R8: A byte store drives a one-hot enable: 4'b1000, 4'b0100, 4'b0010 or 4'b0001 for offsets 0 to 3. It writes store bits 7:0 into all four lanes.
- R9: A word access with a nonzero offset, or a halfword access with an odd offset, raises the error flag, drives all byte enables low and forces the load result to zero.
- R10: The control codes 3'b101, 3'b110 and 3'b111 are reserved, and they behave like a misaligned access.
- R11: When the store strobe is low, all byte enables stay low.
- R12: With the default register stage, every output reflects the inputs of the previous clock cycle, and reset drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register stage |
| rst_ni | input | 1 | Active-low reset of the output stage |
| store_i | input | 1 | High for a store, low for a load |
| ctrl_i | input | 3 | Access size and signedness code |
| addr_lo_i | input | 2 | Byte offset of the access inside its word |
| store_data_i | input | 32 | Store value, right-aligned |
| mem_rdata_i | input | 32 | Word fetched from memory |
| load_data_o | output | 32 | Aligned and extended load result |
| mem_wdata_o | output | 32 | Write word with data copied onto the lanes |
| byte_en_o | output | 4 | Per-lane write enable, bit 3 for bits 31:24 |
| misalign_o | output | 1 | Misaligned or reserved access flag |

## Verification
Error detection and lane masking can fall in the same cycle. When a store breaks alignment, the error flag must rise and the enable mask, which would otherwise be nonzero, must drop in that same output cycle. The bench provokes this with halfword stores at odd offsets, word stores at every nonzero offset and stores with reserved codes, all carrying live data. The scoreboard judges each of these cycles by both the flag and the zero mask. Back-to-back items of different sizes also confirm that the register stage never mixes fields from two neighbouring accesses.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [2:0] {
        CT_WORD   = 3'b000,
        CT_HALF_S = 3'b001,
        CT_HALF_U = 3'b010,
        CT_BYTE_S = 3'b011,
        CT_BYTE_U = 3'b100
    } ctl_e;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    typedef struct packed {
        logic [WORD_W-1:0] ldata;
        logic [WORD_W-1:0] wdata;
        logic [LANES-1:0]  be;
        logic              err;
    } out_t;
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
    import lsa_pkg::*;
(
    input  logic [2:0]       ctrl_i,
    input  logic [OFF_W-1:0] off_i,
    output size_e            size_o,
    output logic             sext_o,
    output logic             err_o
);
    always_comb begin
        size_o = SZ_NONE;
        sext_o = 1'b0;
        case (ctrl_i)
            CT_WORD:   size_o = SZ_WORD;
            CT_HALF_S: begin size_o = SZ_HALF; sext_o = 1'b1; end
            CT_HALF_U: size_o = SZ_HALF;
            CT_BYTE_S: begin size_o = SZ_BYTE; sext_o = 1'b1; end
            CT_BYTE_U: size_o = SZ_BYTE;
            default:   size_o = SZ_NONE;
        endcase
    end

    always_comb begin
        case (size_o)
            SZ_WORD: err_o = (off_i != '0);
            SZ_HALF: err_o = off_i[0];
            SZ_BYTE: err_o = 1'b0;
            default: err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_load_align.sv
module lsa_load_align
    import lsa_pkg::*;
(
    input  logic [WORD_W-1:0] rdata_i,
    input  size_e             size_i,
    input  logic              sext_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              err_i,
    output logic [WORD_W-1:0] ldata_o
);
    logic [HALF_W-1:0] half_v;
    logic [LANE_W-1:0] lane_v;

    always_comb begin
        half_v = off_i[OFF_W-1] ? rdata_i[HALF_W-1:0] : rdata_i[WORD_W-1:HALF_W];
        lane_v = rdata_i[LANE_W*(LANES-1-int'(off_i)) +: LANE_W];
    end

    always_comb begin
        case (size_i)
            SZ_WORD: ldata_o = rdata_i;
            SZ_HALF: ldata_o = {{(WORD_W-HALF_W){sext_i & half_v[HALF_W-1]}}, half_v};
            SZ_BYTE: ldata_o = {{(WORD_W-LANE_W){sext_i & lane_v[LANE_W-1]}}, lane_v};
            default: ldata_o = '0;
        endcase
        if (err_i) begin
            ldata_o = '0;
        end
    end
endmodule

// File: rtl/lsa_store_align.sv
module lsa_store_align
    import lsa_pkg::*;
(
    input  logic [WORD_W-1:0] sdata_i,
    input  size_e             size_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              store_i,
    input  logic              err_i,
    output logic [WORD_W-1:0] wdata_o,
    output logic [LANES-1:0]  be_o
);
    logic [LANES-1:0]  sel;
    logic [LANE_W-1:0] lane_w [LANES];
    logic              go;

    assign go = store_i & ~err_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LOFF = OFF_W'(g);
        localparam int HI = LANE_W * (LANES - 1 - g);

        assign sel[g] = go & ((size_i == SZ_WORD)
                           | ((size_i == SZ_HALF) & (LOFF[OFF_W-1] == off_i[OFF_W-1]))
                           | ((size_i == SZ_BYTE) & (LOFF == off_i)));

        assign lane_w[g] = (size_i == SZ_WORD) ? sdata_i[HI +: LANE_W] :
                           (size_i == SZ_HALF) ? (LOFF[0] ? sdata_i[LANE_W-1:0]
                                                          : sdata_i[2*LANE_W-1:LANE_W]) :
                                                 sdata_i[LANE_W-1:0];

        assign wdata_o[HI +: LANE_W] = lane_w[g];
        assign be_o[LANES-1-g]       = sel[g];
    end
endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit
    import lsa_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              store_i,
    input  logic [2:0]        ctrl_i,
    input  logic [OFF_W-1:0]  addr_lo_i,
    input  logic [WORD_W-1:0] store_data_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [WORD_W-1:0] load_data_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic [LANES-1:0]  byte_en_o,
    output logic              misalign_o
);
    size_e             size_w;
    logic              sext_w;
    logic              err_w;
    logic [WORD_W-1:0] ldata_w;
    logic [WORD_W-1:0] wdata_w;
    logic [LANES-1:0]  be_w;
    out_t              out_d;
    out_t              out_q;

    lsa_decode u_dec (
        .ctrl_i (ctrl_i),
        .off_i  (addr_lo_i),
        .size_o (size_w),
        .sext_o (sext_w),
        .err_o  (err_w)
    );

    lsa_load_align u_ld (
        .rdata_i (mem_rdata_i),
        .size_i  (size_w),
        .sext_i  (sext_w),
        .off_i   (addr_lo_i),
        .err_i   (err_w),
        .ldata_o (ldata_w)
    );

    lsa_store_align u_st (
        .sdata_i (store_data_i),
        .size_i  (size_w),
        .off_i   (addr_lo_i),
        .store_i (store_i),
        .err_i   (err_w),
        .wdata_o (wdata_w),
        .be_o    (be_w)
    );

    always_comb begin
        out_d       = '0;
        out_d.ldata = ldata_w;
        out_d.wdata = wdata_w;
        out_d.be    = be_w;
        out_d.err   = err_w;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign load_data_o = out_q.ldata;
    assign mem_wdata_o = out_q.wdata;
    assign byte_en_o   = out_q.be;
    assign misalign_o  = out_q.err;

    // R9: a flagged access enables no lane
    p_err_no_lanes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_d.err |-> (out_d.be == '0));

    // R9: a flagged access returns zero
    p_err_zero_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_d.err |-> (out_d.ldata == '0));

    // R1, R9: a word at a nonzero offset is flagged
    p_word_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ctrl_i == CT_WORD) && (addr_lo_i != '0)) |-> out_d.err);

    // R10: reserved codes are flagged
    p_reserved_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i > 3'b100) |-> out_d.err);

    // R11: loads never write
    p_load_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !store_i |-> (out_d.be == '0));

    // R8: only legal mask shapes appear
    p_mask_shape_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_d.be inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000,
                          4'b0011, 4'b1100, 4'b1111}));

    // R5: unsigned byte loads carry zero upper bits
    p_unsigned_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i == CT_BYTE_U) |-> (out_d.ldata[WORD_W-1:LANE_W] == '0));
endmodule

// File: tb/lsa_align_unit_tb_top.sv
`timescale 1ns/1ps
module lsa_align_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        store_i = 1'b0;
    logic [2:0]  ctrl_i = 3'b000;
    logic [1:0]  addr_lo_i = 2'b00;
    logic [31:0] store_data_i = '0;
    logic [31:0] mem_rdata_i = '0;
    logic [31:0] load_data_o;
    logic [31:0] mem_wdata_o;
    logic [3:0]  byte_en_o;
    logic        misalign_o;

    typedef struct packed {
        logic [31:0] ld;
        logic [31:0] wd;
        logic [3:0]  be;
        logic        err;
        logic        care_w;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    lsa_align_unit dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .store_i      (store_i),
        .ctrl_i       (ctrl_i),
        .addr_lo_i    (addr_lo_i),
        .store_data_i (store_data_i),
        .mem_rdata_i  (mem_rdata_i),
        .load_data_o  (load_data_o),
        .mem_wdata_o  (mem_wdata_o),
        .byte_en_o    (byte_en_o),
        .misalign_o   (misalign_o)
    );

    function automatic exp_t model(input logic st, input logic [2:0] c,
                                   input logic [1:0] off, input logic [31:0] sd,
                                   input logic [31:0] rd);
        exp_t e;
        logic [7:0]  b;
        logic [15:0] h;
        e = '0;
        b = (off == 2'd0) ? rd[31:24] : (off == 2'd1) ? rd[23:16] :
            (off == 2'd2) ? rd[15:8] : rd[7:0];
        h = (off >= 2'd2) ? rd[15:0] : rd[31:16];
        if (c == 3'b000)      e.err = (off != 2'd0);
        else if (c == 3'b001 || c == 3'b010) e.err = off[0];
        else if (c == 3'b011 || c == 3'b100) e.err = 1'b0;
        else                  e.err = 1'b1;
        if (!e.err) begin
            if (c == 3'b000) begin
                e.ld = rd; e.wd = sd; e.be = 4'b1111;
            end else if (c == 3'b001 || c == 3'b010) begin
                e.ld = (c == 3'b001 && h[15]) ? {16'hFFFF, h} : {16'h0000, h};
                e.wd = {sd[15:0], sd[15:0]};
                e.be = (off == 2'd0) ? 4'b1100 : 4'b0011;
            end else begin
                e.ld = (c == 3'b011 && b[7]) ? {24'hFFFFFF, b} : {24'h0, b};
                e.wd = {4{sd[7:0]}};
                e.be = 4'b1000 >> off;
            end
            if (!st) e.be = 4'b0000;
        end
        e.care_w = st && !e.err;
        return e;
    endfunction

    task automatic drive(input string tag, input logic st, input logic [2:0] c,
                         input logic [1:0] off, input logic [31:0] sd,
                         input logic [31:0] rd);
        @(negedge clk);
        store_i = st; ctrl_i = c; addr_lo_i = off;
        store_data_i = sd; mem_rdata_i = rd;
        exp_q.push_back(model(st, c, off, sd, rd));
        tag_q.push_back(tag);
    endtask

    task automatic check1(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // monitor: pops one expected item per cycle, one register stage after drive (R12)
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check1({t, " load"}, load_data_o, e.ld);
                check1({t, " be"}, {28'h0, byte_en_o}, {28'h0, e.be});
                check1({t, " err"}, {31'h0, misalign_o}, {31'h0, e.err});
                if (e.care_w) check1({t, " wdata"}, mem_wdata_o, e.wd);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        store_i = 1'b1; ctrl_i = 3'b000; store_data_i = 32'hFFFF_FFFF;
        mem_rdata_i = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        // R12: reset clears all outputs
        check1("R12 reset load", load_data_o, 32'h0);
        check1("R12 reset wdata", mem_wdata_o, 32'h0);
        check1("R12 reset be/err", {27'h0, byte_en_o, misalign_o}, 32'h0);
        @(negedge clk);
        rst_ni = 1'b1;

        drive("R1 word load", 1'b0, 3'b000, 2'd0, 32'h0, 32'h8123_4567);
        for (int o = 0; o < 4; o++) begin
            drive("R2 R4 byte signed", 1'b0, 3'b011, 2'(o), 32'h0, 32'h807F_C301);
            drive("R2 R5 byte unsigned", 1'b0, 3'b100, 2'(o), 32'h0, 32'h807F_C301);
        end
        drive("R3 R4 half signed off0", 1'b0, 3'b001, 2'd0, 32'h0, 32'h9ABC_1234);
        drive("R3 R4 half signed off2", 1'b0, 3'b001, 2'd2, 32'h0, 32'h1234_9ABC);
        drive("R3 R5 half unsigned off0", 1'b0, 3'b010, 2'd0, 32'h0, 32'h9ABC_1234);
        drive("R3 R5 half unsigned off2", 1'b0, 3'b010, 2'd2, 32'h0, 32'h1234_F00D);
        drive("R6 word store", 1'b1, 3'b000, 2'd0, 32'hDEAD_BEEF, 32'h0);
        drive("R7 half store off0", 1'b1, 3'b010, 2'd0, 32'h1111_BEEF, 32'h0);
        drive("R7 half store off2", 1'b1, 3'b001, 2'd2, 32'h2222_CAFE, 32'h0);
        for (int o = 0; o < 4; o++) begin
            drive("R8 byte store", 1'b1, 3'b100, 2'(o), 32'h1234_56A5, 32'h0);
        end
        for (int o = 1; o < 4; o++) begin
            drive("R9 word misaligned load", 1'b0, 3'b000, 2'(o), 32'h0, 32'hFFFF_FFFF);
            drive("R9 word misaligned store", 1'b1, 3'b000, 2'(o), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        end
        drive("R9 half misaligned store off1", 1'b1, 3'b001, 2'd1, 32'h0000_ABCD, 32'hFFFF_FFFF);
        drive("R9 half misaligned load off3", 1'b0, 3'b010, 2'd3, 32'h0, 32'hFFFF_FFFF);
        for (int c = 5; c < 8; c++) begin
            drive("R10 reserved code", 1'b1, 3'(c), 2'd0, 32'h5555_5555, 32'hAAAA_AAAA);
        end
        drive("R11 load word no write", 1'b0, 3'b000, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001);
        drive("R11 load byte no write", 1'b0, 3'b011, 2'd3, 32'hFFFF_FFFF, 32'h0000_00FF);
        drive("R12 back-to-back store", 1'b1, 3'b011, 2'd1, 32'h0000_0077, 32'h0);
        drive("R12 back-to-back load", 1'b0, 3'b001, 2'd2, 32'h0, 32'h0000_8001);

        @(negedge clk);
        store_i = 1'b0; ctrl_i = 3'b000; addr_lo_i = 2'd0;
        while (exp_q.size() > 0) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule